// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 128 pins. The pins are arranged as four banks of 32. Software uses a simple 32-bit register bus to make each pin an input or an output, to raise or lower output latch bits through separate set and clear words, and to read the effective pin level. It also arms per-pin rising and falling edge detection and acknowledges sticky edge flags. Each bank also holds two alternate-function words. These words are plain storage and select nothing.

On the pin side, every external input passes through a two-stage synchronizer. An edge is found by comparing the synchronized level with its value one clock earlier. There are three interrupt lines. One follows the flag of pin 0, one follows the flag of pin 1, and the third is the OR of every other flag in all banks. While a sleep input is high, a level change on a wake-capable input pin produces a one-cycle wake request.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every stored word is zero, all register reads return zero, and pin_out, pin_oe, the three interrupt lines and wake_req are low.
- R2: Register addresses use a byte offset. Bits [1:0] are ignored. Each per-bank function has a base: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge flags 0x48. Banks 0 to 2 sit at base + 4*bank. Bank 3 sits at base + 0x100. Alternate-function words sit at 0x54 + 8*bank (low) and 0x58 + 8*bank (high).
- R3: A write to a set word ORs the data into that bank's output latch. A write to a clear word clears each latch bit written as 1. Set and clear words read as zero. The latch keeps its value whatever the direction.
- R4: A direction bit of 1 makes a pin an output. pin_oe equals the direction bits, and pin_out equals latch AND direction.
- R5: A level read returns the latch bit for output pins and the synchronized input for input pins. An input change made between clock edges is visible to a read after the second rising edge, and not after the first.
- R6: A 0-to-1 change on an input pin whose rising enable is 1 sets its edge flag. The flag reads as 1 after the third rising edge following the pin change. Pins with the enable at 0 are not flagged.
- R7: A 1-to-0 change on an input pin whose falling enable is 1 sets its edge flag with the same latency. With the falling enable at 0, a falling change leaves the flag untouched.
- R8: Writing an edge-flag word clears each flag written as 1 and leaves the others. If a new edge and such a clear reach the same flag in the same cycle, the flag stays set.
- R9: irq_pin0 follows the flag of bank 0 pin 0. irq_pin1 follows the flag of bank 0 pin 1. irq_other is high while any other flag in any bank is set.
- R10: While sleep_mode is high, a level change on an input pin whose bit is set in the fixed wake mask gives a one-cycle wake_req pulse after the third rising edge. The wake masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. Changes on output pins, on unmasked pins, or while sleep_mode is low give no pulse.
- R11: Each of the eight alternate-function words stores any 32-bit value and reads it back unchanged.
- R12: Offsets of 0x200 and above, and unassigned offsets below 0x200, read as zero and ignore writes.
- R13: An edge on a pin configured as an output never sets its flag, even when its edge enables are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr_en | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 128 | External pin levels, asynchronous |
| pin_out | output | 128 | Driven pin values |
| pin_oe | output | 128 | Pin output enables |
| sleep_mode | input | 1 | High while the system sleeps |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_other | output | 1 | Interrupt for all remaining pins |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
Register writes take effect at the rising edge that samples the strobe, and bus_rdata is combinational, so the bench reads back at the next falling edge. An input change made at a falling edge reaches the level read after two rising edges. It reaches the edge flags, the interrupt lines and wake_req after three. The bench samples one cycle before and at the due cycle to catch both early and late results. For wake_req it also samples one cycle after the due cycle, to confirm a single-cycle pulse. The clear-versus-edge collision is timed so that the clearing write commits at the same third edge where the new flag lands.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int BANKS  = 4;
  localparam int PINS   = 32;
  localparam int AW     = 12;
  localparam int DW     = 32;
  localparam int NPIN   = BANKS * PINS;
  localparam int GROUPS = 7;            // per-bank function groups below the AF words
  localparam int AF_W0  = GROUPS * 3;   // first alternate-function word index
  localparam int HI_W0  = 64;           // word index of the upper bank region

  typedef enum logic [3:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_STAT, K_AFLO, K_AFHI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  function automatic reg_kind_e group_kind(input int grp);
    case (grp)
      0: return K_LEVEL;
      1: return K_DIR;
      2: return K_SET;
      3: return K_CLR;
      4: return K_RISE;
      5: return K_FALL;
      6: return K_STAT;
      default: return K_NONE;
    endcase
  endfunction

  function automatic reg_sel_t decode_offset(input logic [AW-1:0] off);
    reg_sel_t sel;
    int w;
    int h;
    sel.kind = K_NONE;
    sel.bank = 2'd0;
    w = int'(off[8:2]);
    if (off[AW-1:9] == '0) begin
      if (w < AF_W0) begin
        sel.kind = group_kind(w / 3);
        sel.bank = 2'(w % 3);
      end else if (w < AF_W0 + 2 * BANKS) begin
        h = w - AF_W0;
        sel.kind = (h % 2 == 1) ? K_AFHI : K_AFLO;
        sel.bank = 2'(h / 2);
      end else if (w >= HI_W0 && w < HI_W0 + AF_W0) begin
        h = w - HI_W0;
        if (h % 3 == 0) begin
          sel.kind = group_kind(h / 3);
          sel.bank = 2'd3;
        end
      end
    end
    return sel;
  endfunction

  function automatic logic [PINS-1:0] wake_mask(input int bank);
    case (bank)
      0: return 32'h8003_FE1B;
      1: return 32'h0020_01FC;
      2: return 32'hEC08_0000;
      3: return 32'h0012_007F;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PINS-1:0] edge_hits(input logic [PINS-1:0] now_v,
                                                input logic [PINS-1:0] was_v,
                                                input logic [PINS-1:0] rise_en,
                                                input logic [PINS-1:0] fall_en,
                                                input logic [PINS-1:0] dir);
    return ((now_v & ~was_v & rise_en) | (~now_v & was_v & fall_en)) & ~dir;
  endfunction

  function automatic logic [PINS-1:0] merge_level(input logic [PINS-1:0] latch,
                                                  input logic [PINS-1:0] dir,
                                                  input logic [PINS-1:0] in_v);
    return (latch & dir) | (in_v & ~dir);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 128,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[LAST];
  end

  assign sync_o = chain_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_edge_pkg::*;
#(
  parameter int BANK_IDX = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_kind_e       wr_kind,
  input  logic [DW-1:0]   wdata,
  input  logic [PINS-1:0] pin_s,
  input  logic [PINS-1:0] pin_p,
  output logic [PINS-1:0] dir_o,
  output logic [PINS-1:0] latch_o,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o,
  output logic [PINS-1:0] stat_o,
  output logic [DW-1:0]   aflo_o,
  output logic [DW-1:0]   afhi_o,
  output logic [PINS-1:0] level_o,
  output logic [PINS-1:0] edge_set_o,
  output logic            wake_hit_o
);
  localparam logic [PINS-1:0] WMASK = wake_mask(BANK_IDX);

  logic [PINS-1:0] dir_q, latch_q, rise_q, fall_q, stat_q;
  logic [DW-1:0]   aflo_q, afhi_q;
  logic [PINS-1:0] ack_bits, stat_d;

  assign edge_set_o = edge_hits(pin_s, pin_p, rise_q, fall_q, dir_q);
  assign ack_bits   = (wr_en && wr_kind == K_STAT) ? wdata : '0;
  assign stat_d     = (stat_q & ~ack_bits) | edge_set_o;
  assign level_o    = merge_level(latch_q, dir_q, pin_s);
  assign wake_hit_o = |((pin_s ^ pin_p) & ~dir_q & WMASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      stat_q  <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en) begin
        case (wr_kind)
          K_DIR:  dir_q   <= wdata;
          K_SET:  latch_q <= latch_q | wdata;
          K_CLR:  latch_q <= latch_q & ~wdata;
          K_RISE: rise_q  <= wdata;
          K_FALL: fall_q  <= wdata;
          K_AFLO: aflo_q  <= wdata;
          K_AFHI: afhi_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign dir_o   = dir_q;
  assign latch_o = latch_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign stat_o  = stat_q;
  assign aflo_o  = aflo_q;
  assign afhi_o  = afhi_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr_en,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic            sleep_mode,
  output logic            irq_pin0,
  output logic            irq_pin1,
  output logic            irq_other,
  output logic            wake_req
);
  reg_sel_t sel;
  logic [NPIN-1:0] pin_s, pin_p;
  logic [NPIN-1:0] status_all, edge_set_all, dir_all, olat_all;
  logic [BANKS-1:0][PINS-1:0] dir_b, latch_b, rise_b, fall_b, stat_b, level_b, eset_b;
  logic [BANKS-1:0][DW-1:0]   aflo_b, afhi_b;
  logic [BANKS-1:0]           wake_hit_b;
  logic                       wake_q;

  assign sel = decode_offset(bus_addr);

  gpio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_in), .sync_o(pin_s), .prev_o(pin_p)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr_en && (sel.kind != K_NONE) && (int'(sel.bank) == b);

    gpio_bank #(.BANK_IDX(b)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bank_wr), .wr_kind(sel.kind), .wdata(bus_wdata),
      .pin_s(pin_s[b*PINS +: PINS]), .pin_p(pin_p[b*PINS +: PINS]),
      .dir_o(dir_b[b]), .latch_o(latch_b[b]), .rise_o(rise_b[b]), .fall_o(fall_b[b]),
      .stat_o(stat_b[b]), .aflo_o(aflo_b[b]), .afhi_o(afhi_b[b]),
      .level_o(level_b[b]), .edge_set_o(eset_b[b]), .wake_hit_o(wake_hit_b[b])
    );

    assign status_all[b*PINS +: PINS]   = stat_b[b];
    assign edge_set_all[b*PINS +: PINS] = eset_b[b];
    assign dir_all[b*PINS +: PINS]      = dir_b[b];
    assign olat_all[b*PINS +: PINS]     = latch_b[b];
  end

  always_comb begin
    case (sel.kind)
      K_LEVEL: bus_rdata = level_b[sel.bank];
      K_DIR:   bus_rdata = dir_b[sel.bank];
      K_RISE:  bus_rdata = rise_b[sel.bank];
      K_FALL:  bus_rdata = fall_b[sel.bank];
      K_STAT:  bus_rdata = stat_b[sel.bank];
      K_AFLO:  bus_rdata = aflo_b[sel.bank];
      K_AFHI:  bus_rdata = afhi_b[sel.bank];
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= sleep_mode && (|wake_hit_b);
  end

  assign pin_oe    = dir_all;
  assign pin_out   = olat_all & dir_all;
  assign irq_pin0  = status_all[0];
  assign irq_pin1  = status_all[1];
  assign irq_other = |status_all[NPIN-1:2];
  assign wake_req  = wake_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr_en,
  input logic [DW-1:0]   bus_wdata,
  input logic            sleep_mode,
  input logic            irq_pin0,
  input logic            wake_req,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] status_all,
  input logic [NPIN-1:0] edge_set_all,
  input logic [NPIN-1:0] dir_all,
  input logic [NPIN-1:0] olat_all
);
  reg_sel_t csel;
  logic     wr_stat0;
  assign csel     = decode_offset(bus_addr);
  assign wr_stat0 = bus_wr_en && csel.kind == K_STAT && csel.bank == 2'd0;

  a_r4_out_within_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r9_irq0_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pin0) |-> $past(edge_set_all[0]));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat0 |=> ((status_all[PINS-1:0] & $past(bus_wdata) & ~$past(edge_set_all[PINS-1:0])) == '0));

  a_r13_no_flag_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (status_all & ~$past(status_all) & $past(dir_all)) == '0);

  a_r10_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(sleep_mode));

  a_r12_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[AW-1:9] != '0) |=>
      (dir_all == $past(dir_all)) && (olat_all == $past(olat_all)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_wdata(bus_wdata), .sleep_mode(sleep_mode), .irq_pin0(irq_pin0),
  .wake_req(wake_req), .pin_out(pin_out), .pin_oe(pin_oe),
  .status_all(status_all), .edge_set_all(edge_set_all),
  .dir_all(dir_all), .olat_all(olat_all)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic         bus_wr_en = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic         sleep_mode = 1'b0;
  logic         irq_pin0, irq_pin1, irq_other, wake_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .sleep_mode(sleep_mode),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_other(irq_other),
    .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); chk("R1 level0", v, 0);
    rd(12'h10C, v); chk("R1 dir3", v, 0);
    rd(12'h048, v); chk("R1 stat0", v, 0);
    chk("R1 outputs", {28'h0, irq_pin0, irq_pin1, irq_other, wake_req} | 32'(|pin_out) | 32'(|pin_oe), 0);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr(12'h010, 32'hFFFF_0000);
    wr(12'h01C, 32'h00FF_00F0);
    rd(12'h004, v); chk("R5 level of outputs", v, 32'h00FF_0000);
    chk("R4 pin_out bank1", pin_out[63:32], 32'h00FF_0000);
    chk("R4 pin_oe bank1", pin_oe[63:32], 32'hFFFF_0000);
    rd(12'h010, v); chk("R2 dir1 readback", v, 32'hFFFF_0000);
    wr(12'h028, 32'h000F_0000);
    chk("R3 clear", pin_out[63:32], 32'h00F0_0000);
    rd(12'h01C, v); chk("R3 set reads zero", v, 0);
    rd(12'h028, v); chk("R3 clear reads zero", v, 0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h004, v); chk("R3 latch kept on inputs", v, 32'h00F0_00F0);
    wr(12'h10C, 32'h1);
    wr(12'h118, 32'h1);
    chk("R2 bank3 set", pin_out[127:96], 32'h1);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pin_in[95:64] = 32'hA5A5_0000;
    cyc(1);
    rd(12'h008, v); chk("R5 not after one edge", v, 0);
    cyc(1);
    rd(12'h008, v); chk("R5 after two edges", v, 32'hA5A5_0000);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(12'h030, 32'h23);
    pin_in[0] = 1'b1; pin_in[7] = 1'b1;
    cyc(2);
    rd(12'h048, v); chk("R6 flag not early", v, 0);
    cyc(1);
    rd(12'h048, v); chk("R6 rise flag", v, 32'h1);
    chk("R9 irq0/irq_other", {30'h0, irq_pin0, irq_other}, 32'h2);
    pin_in[5] = 1'b1;
    cyc(3);
    chk("R9 irq_other", 32'(irq_other), 1);
    rd(12'h048, v); chk("R6 two flags", v, 32'h21);
    pin_in[0] = 1'b0;
    cyc(4);
    rd(12'h048, v); chk("R7 fall disabled", v, 32'h21);
    wr(12'h048, 32'h1);
    rd(12'h048, v); chk("R8 w1c one bit", v, 32'h20);
    chk("R9 after ack", {30'h0, irq_pin0, irq_other}, 32'h1);
    wr(12'h048, 32'h20);
    chk("R9 irq_other low", 32'(irq_other), 0);
    wr(12'h03C, 32'h2);
    pin_in[1] = 1'b1;
    cyc(3);
    chk("R9 irq_pin1", 32'(irq_pin1), 1);
    wr(12'h048, 32'h2);
    pin_in[1] = 1'b0;
    cyc(1);
    rd(12'h048, v); chk("R7 fall not early", v, 0);
    wr(12'h048, 32'h2);
    rd(12'h048, v); chk("R8 edge beats clear", v, 32'h2);
    wr(12'h048, 32'h2);
    rd(12'h048, v); chk("R8 cleared", v, 0);
  endtask

  task automatic t_output_pin();
    logic [31:0] v;
    wr(12'h130, 32'h1);
    pin_in[96] = 1'b1;
    cyc(4);
    rd(12'h148, v); chk("R13 no flag on output", v, 0);
    pin_in[96] = 1'b0;
    cyc(3);
    rd(12'h100, v); chk("R5 output level from latch", v & 32'h1, 32'h1);
  endtask

  task automatic t_wake();
    logic seen;
    seen = 1'b0;
    pin_in[3] = 1'b1;
    repeat (4) begin cyc(1); seen |= wake_req; end
    chk("R10 no wake awake", 32'(seen), 0);
    sleep_mode = 1'b1;
    cyc(2);
    seen = 1'b0;
    pin_in[2] = 1'b1;
    repeat (4) begin cyc(1); seen |= wake_req; end
    chk("R10 unmasked pin", 32'(seen), 0);
    seen = 1'b0;
    pin_in[96] = 1'b1;
    repeat (4) begin cyc(1); seen |= wake_req; end
    chk("R10 output pin", 32'(seen), 0);
    pin_in[3] = 1'b0;
    cyc(2); chk("R10 not early", 32'(wake_req), 0);
    cyc(1); chk("R10 pulse", 32'(wake_req), 1);
    cyc(1); chk("R10 one cycle", 32'(wake_req), 0);
    pin_in[95] = 1'b0;
    cyc(3); chk("R10 bank2 bit31", 32'(wake_req), 1);
    sleep_mode = 1'b0;
    cyc(1);
  endtask

  task automatic t_altfn();
    logic [31:0] v;
    wr(12'h054, 32'h1111_1111);
    wr(12'h058, 32'h2222_2222);
    wr(12'h05C, 32'h3333_3333);
    wr(12'h06C, 32'h4444_4444);
    wr(12'h070, 32'h5555_5555);
    rd(12'h054, v); chk("R11 af0 lo", v, 32'h1111_1111);
    rd(12'h058, v); chk("R11 af0 hi", v, 32'h2222_2222);
    rd(12'h05C, v); chk("R11 af1 lo", v, 32'h3333_3333);
    rd(12'h06C, v); chk("R11 af3 lo", v, 32'h4444_4444);
    rd(12'h070, v); chk("R11 af3 hi", v, 32'h5555_5555);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h20C, 32'hFFFF_FFFF);
    rd(12'h10C, v); chk("R12 high write ignored", v, 32'h1);
    rd(12'h20C, v); chk("R12 high read zero", v, 0);
    wr(12'h074, 32'hFFFF_FFFF);
    rd(12'h074, v); chk("R12 hole reads zero", v, 0);
    rd(12'h00C, v); chk("R12 hole write ignored", v, 0);
    rd(12'h104, v); chk("R12 bank3 gap", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_outputs();
    t_level();
    t_edges();
    t_output_pin();
    t_wake();
    t_altfn();
    t_unmapped();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule